// File: doc/BRIEF.md
# ADC Conversion Trigger and Capture

This block paces a sampling A/D converter that starts on a rising edge of its start-convert input and reports progress on an end-of-conversion (EOC) flag. While enabled, it drives the start-convert pin with a periodic pulse. The period and the high time are both counted in system clock cycles. A requested high time that the converter cannot accept is moved to the nearest legal value, and a configuration error flag is raised. The high time may not end inside the forbidden falling-edge band, and the low time between starts may not fall below its minimum.

The EOC flag is asynchronous to the system clock. It passes through a synchronizer, and the falling edge of the synchronized flag triggers capture of the 14-bit result word. That word is presented for one cycle as a strobe, in raw offset-binary form and in two's-complement form. If a start pulse rises while the converter is still busy, the converter restarts and gives an inaccurate result. The block therefore tags the next two captured samples as bad.

Top module: `adc_trigger_capture`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, start_conv, out_valid, out_bad and config_error are 0, and out_raw and out_twos are all zeros.
- R2: After enable is first sampled high, start_conv is 1 from the next cycle on. With effective period P and effective high time W, the sample taken i cycles after that edge is 1 exactly when (i mod P) < W.
- R3: A clock edge that samples enable low drives start_conv to 0. The next enable restarts the pattern at i = 0.
- R4: A width strictly between WIN1_MAX (11) and WIN2_MIN (16) is moved to the nearer of the two limits, with ties going to WIN1_MAX. config_error is 1 from the cycle after such a setting is applied.
- R5: Width 0 becomes 1. A period below MIN_LOW+1 (4) becomes MIN_LOW+1. A width above the period minus MIN_LOW (3) becomes the period minus MIN_LOW, and if that value lies in the forbidden band it becomes WIN1_MAX. Any of these adjustments sets config_error.
- R6: The clock edge that samples EOC low after it was high is counted as edge 0. At edge 2, out_valid rises for exactly one cycle and out_raw holds the adc_data word sampled at that edge. adc_data[13] is the MSB.
- R7: out_twos equals out_raw with its MSB inverted. So 0x2000 gives 0x0000, 0x3FFF gives 0x1FFF, and 0x0000 gives 0x2000.
- R8: A start_conv rising edge while the converter is seen busy causes the next two captures to carry out_bad = 1. Busy means the synchronized EOC, including the cycle in which its fall is detected. The capture after those two carries out_bad = 0. out_bad is only ever 1 together with out_valid.
- R9: Without a falling edge of EOC, no out_valid is produced, and out_raw keeps its value whatever adc_data or a rising edge of EOC does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the periodic start pulse |
| period | input | 16 | Sample period in clock cycles |
| width | input | 16 | Requested start pulse high time in cycles |
| eoc | input | 1 | Converter busy flag, asynchronous |
| adc_data | input | 14 | Converter result word, bit 13 MSB |
| start_conv | output | 1 | Start-convert pulse to the converter |
| out_valid | output | 1 | One-cycle strobe for a new sample |
| out_raw | output | 14 | Captured offset-binary sample |
| out_twos | output | 14 | Captured sample in two's complement |
| out_bad | output | 1 | Sample invalidated by a restart |
| config_error | output | 1 | Period or width setting was adjusted |

## Verification
Capturing a finished sample and arming the invalid tag for a restart can happen in the same cycle. This occurs when a start pulse rises in the cycle where the synchronized EOC fall is detected. The bench provokes it by raising enable exactly one edge after EOC is seen low. The sample captured in that cycle must still report out_bad = 0, and the two following captures must report out_bad = 1. A separate sequence checks the plain restart, where the start pulse rises while EOC is steadily high.

// File: rtl/adctc_pkg.sv
// Shared widths and types for the conversion trigger and capture block.
package adctc_pkg;
    localparam int CNT_W  = 16;  // period / width counter width
    localparam int DATA_W = 14;  // converter result width

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [DATA_W-1:0] sample_t;
endpackage

// File: rtl/adctc_pulse_gen.sv
// Periodic start-convert pulse generator.
// Legalises the requested period/width against the forbidden falling-edge
// band and the minimum low time, and latches the legal values once per
// period so a pulse never changes shape midway.
// Assumes period and width are quasi-static relative to the clock.
module adctc_pulse_gen
    import adctc_pkg::*;
#(
    parameter int WIN1_MAX = 11,
    parameter int WIN2_MIN = 16,
    parameter int MIN_LOW  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  cnt_t period,
    input  cnt_t width,
    output logic start_conv,
    output logic config_error
);
    localparam cnt_t L_W1  = cnt_t'(WIN1_MAX);
    localparam cnt_t L_W2  = cnt_t'(WIN2_MIN);
    localparam cnt_t L_ML  = cnt_t'(MIN_LOW);
    localparam cnt_t L_PMN = cnt_t'(MIN_LOW + 1);

    cnt_t p_eff, w_a, w_b, w_eff;
    cnt_t p_lat, w_lat, cnt;
    logic err;

    // Legalise the requested settings.
    always_comb begin
        err   = 1'b0;
        p_eff = period;
        if (period < L_PMN) begin
            p_eff = L_PMN;
            err   = 1'b1;
        end
        w_a = width;
        if (width == '0) begin
            w_a = cnt_t'(1);
            err = 1'b1;
        end else if (width > L_W1 && width < L_W2) begin
            err = 1'b1;
            w_a = ((width - L_W1) <= (L_W2 - width)) ? L_W1 : L_W2;
        end
        w_b = w_a;
        if (w_a > p_eff - L_ML) begin
            w_b = p_eff - L_ML;
            err = 1'b1;
        end
        w_eff = (w_b > L_W1 && w_b < L_W2) ? L_W1 : w_b;
    end

    // Phase counter, per-period latch of the settings and the pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            p_lat      <= L_PMN;
            w_lat      <= cnt_t'(1);
            start_conv <= 1'b0;
        end else if (!enable) begin
            cnt        <= '0;
            p_lat      <= p_eff;
            w_lat      <= w_eff;
            start_conv <= 1'b0;
        end else begin
            start_conv <= (cnt < w_lat);
            if (cnt >= p_lat - cnt_t'(1)) begin
                cnt   <= '0;
                p_lat <= p_eff;
                w_lat <= w_eff;
            end else begin
                cnt <= cnt + cnt_t'(1);
            end
        end
    end

    // Registered configuration error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) config_error <= 1'b0;
        else        config_error <= err;
    end
endmodule

// File: rtl/adctc_eoc_sync.sv
// Synchronizer and falling-edge detector for the converter busy flag.
// The last stage is the edge reference: busy is high until the fall is
// consumed. Assumes eoc is asynchronous and glitch-free.
module adctc_eoc_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eoc,
    output logic eoc_fall,
    output logic eoc_busy
);
    logic [SYNC_STAGES:0] sh;

    // Shift the flag through the synchronizer plus one edge-reference stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[SYNC_STAGES-1:0], eoc};
    end

    assign eoc_fall = sh[SYNC_STAGES] & ~sh[SYNC_STAGES-1];
    assign eoc_busy = sh[SYNC_STAGES];
endmodule

// File: rtl/adctc_capture.sv
// Latches the result word on a synchronized EOC fall, converts it to two's
// complement and tags samples spoiled by a restart of a busy converter.
// Assumes adc_data is stable for several cycles after EOC falls.
module adctc_capture
    import adctc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start_conv,
    input  logic    eoc_fall,
    input  logic    eoc_busy,
    input  sample_t adc_data,
    output logic    out_valid,
    output sample_t out_raw,
    output sample_t out_twos,
    output logic    out_bad
);
    logic       start_d;
    logic [1:0] bad_left;
    logic       start_rise;

    assign start_rise = start_conv & ~start_d;

    // Remember the previous start level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) start_d <= 1'b0;
        else        start_d <= start_conv;
    end

    // Count how many upcoming captures must be tagged invalid.
    always_ff @(posedge clk) begin
        if (!rst_n)                             bad_left <= 2'd0;
        else if (start_rise && eoc_busy)        bad_left <= 2'd2;
        else if (eoc_fall && bad_left != 2'd0)  bad_left <= bad_left - 2'd1;
    end

    // Capture the sample and present it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_raw   <= '0;
            out_twos  <= '0;
            out_bad   <= 1'b0;
        end else begin
            out_valid <= eoc_fall;
            out_bad   <= eoc_fall && (bad_left != 2'd0);
            if (eoc_fall) begin
                out_raw  <= adc_data;
                out_twos <= {~adc_data[DATA_W-1], adc_data[DATA_W-2:0]};
            end
        end
    end
endmodule

// File: rtl/adc_trigger_capture.sv
// Top level: periodic start-convert generation plus result capture for a
// sampling converter with a parallel offset-binary output.
// Assumes the converter asserts eoc during conversion and drives stable
// data before eoc falls.
module adc_trigger_capture
    import adctc_pkg::*;
#(
    parameter int WIN1_MAX    = 11,
    parameter int WIN2_MIN    = 16,
    parameter int MIN_LOW     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CNT_W-1:0]  period,
    input  logic [CNT_W-1:0]  width,
    input  logic              eoc,
    input  logic [DATA_W-1:0] adc_data,
    output logic              start_conv,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_raw,
    output logic [DATA_W-1:0] out_twos,
    output logic              out_bad,
    output logic              config_error
);
    logic eoc_fall, eoc_busy;

    adctc_pulse_gen #(
        .WIN1_MAX(WIN1_MAX), .WIN2_MIN(WIN2_MIN), .MIN_LOW(MIN_LOW)
    ) u_pulse (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .period(period), .width(width),
        .start_conv(start_conv), .config_error(config_error)
    );

    adctc_eoc_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .eoc(eoc),
        .eoc_fall(eoc_fall), .eoc_busy(eoc_busy)
    );

    adctc_capture u_cap (
        .clk(clk), .rst_n(rst_n), .start_conv(start_conv),
        .eoc_fall(eoc_fall), .eoc_busy(eoc_busy), .adc_data(adc_data),
        .out_valid(out_valid), .out_raw(out_raw), .out_twos(out_twos),
        .out_bad(out_bad)
    );
endmodule

// File: rtl/adctc_checker.sv
// Property checker for adc_trigger_capture, attached by bind below.
// Observes ports only; pulse-length windows are measured with counters.
module adctc_checker
    import adctc_pkg::*;
#(
    parameter int WIN1_MAX = 11,
    parameter int WIN2_MIN = 16,
    parameter int MIN_LOW  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              start_conv,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_raw,
    input logic              out_bad
);
    int   hi_cnt, lo_cnt;
    logic armed;

    // Measure the current high and low run lengths of start_conv.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= 0;
            lo_cnt <= 0;
            armed  <= 1'b0;
        end else begin
            hi_cnt <= start_conv ? ((hi_cnt < 100000) ? hi_cnt + 1 : hi_cnt) : 0;
            lo_cnt <= start_conv ? 0 : ((lo_cnt < 100000) ? lo_cnt + 1 : lo_cnt);
            armed  <= enable && (armed || start_conv);
        end
    end

    p_off_when_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !start_conv);

    p_no_forbidden_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(start_conv) && $past(enable)) |->
            (hi_cnt <= WIN1_MAX || hi_cnt >= WIN2_MIN));

    p_min_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(start_conv) && armed) |-> (lo_cnt >= MIN_LOW));

    p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_bad_with_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_bad |-> out_valid);

    p_hold_raw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_raw));
endmodule

bind adc_trigger_capture adctc_checker #(
    .WIN1_MAX(WIN1_MAX), .WIN2_MIN(WIN2_MIN), .MIN_LOW(MIN_LOW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start_conv(start_conv),
    .out_valid(out_valid), .out_raw(out_raw), .out_bad(out_bad)
);

// File: tb/adc_trigger_capture_test.sv
module adc_trigger_capture_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] period = 16'd10;
    logic [15:0] width = 16'd4;
    logic        eoc = 1'b0;
    logic [13:0] adc_data = '0;
    logic        start_conv, out_valid, out_bad, config_error;
    logic [13:0] out_raw, out_twos;

    int tests = 0;
    int failed = 0;
    bit done = 0;

    always #4 clk = ~clk;

    adc_trigger_capture uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .period(period),
        .width(width), .eoc(eoc), .adc_data(adc_data),
        .start_conv(start_conv), .out_valid(out_valid), .out_raw(out_raw),
        .out_twos(out_twos), .out_bad(out_bad), .config_error(config_error)
    );

    // period, width, expected period, expected width, expected error, tag (4/5)
    localparam int NV = 11;
    localparam int VEC [0:NV-1][0:5] = '{
        '{10,  4, 10,  4, 0, 2},
        '{40, 11, 40, 11, 0, 2},
        '{40, 16, 40, 16, 0, 2},
        '{40, 13, 40, 11, 1, 4},
        '{40, 14, 40, 16, 1, 4},
        '{10,  9, 10,  7, 1, 5},
        '{20, 18, 20, 17, 1, 5},
        '{17, 16, 17, 11, 1, 5},
        '{30,  0, 30,  1, 1, 5},
        '{ 2,  1,  4,  1, 1, 5},
        '{60, 40, 60, 40, 0, 2}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One conversion: EOC high, then falls with data; check the capture.
    task automatic do_conv(input logic [13:0] d, input logic [13:0] twos, input logic bad);
        @(negedge clk) eoc = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk) begin eoc = 1'b0; adc_data = d; end
        repeat (2) @(posedge clk);
        @(negedge clk) chk("R6 no early strobe", {31'd0, out_valid}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R6 strobe", {31'd0, out_valid}, 32'd1);
        chk("R6 raw", {18'd0, out_raw}, {18'd0, d});
        chk("R7 twos", {18'd0, out_twos}, {18'd0, twos});
        chk("R8 bad tag", {31'd0, out_bad}, {31'd0, bad});
        @(negedge clk) chk("R6 one cycle", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            failed++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) begin
            chk("R1 start", {31'd0, start_conv}, 32'd0);
            chk("R1 valid", {31'd0, out_valid}, 32'd0);
            rst_n = 1'b1;
        end
        @(negedge clk);
        chk("R1 start", {31'd0, start_conv}, 32'd0);
        chk("R1 valid", {31'd0, out_valid}, 32'd0);
        chk("R1 bad", {31'd0, out_bad}, 32'd0);
        chk("R1 err", {31'd0, config_error}, 32'd0);
        chk("R1 raw", {18'd0, out_raw}, 32'd0);
        chk("R1 twos", {18'd0, out_twos}, 32'd0);

        // Vector table: pulse shape and setting legalisation.
        for (int v = 0; v < NV; v++) begin
            period = 16'(VEC[v][0]);
            width  = 16'(VEC[v][1]);
            @(posedge clk);
            @(negedge clk);
            chk((VEC[v][5] == 4) ? "R4 error flag" :
                (VEC[v][5] == 5) ? "R5 error flag" : "R2 error flag",
                {31'd0, config_error}, 32'(VEC[v][4]));
            enable = 1'b1;
            for (int i = 0; i < 2 * VEC[v][2]; i++) begin
                @(negedge clk);
                chk((VEC[v][5] == 4) ? "R4 pulse shape" :
                    (VEC[v][5] == 5) ? "R5 pulse shape" : "R2 pulse shape",
                    {31'd0, start_conv},
                    {31'd0, (i % VEC[v][2]) < VEC[v][3]});
            end
            enable = 1'b0;
            @(negedge clk) chk("R3 disable", {31'd0, start_conv}, 32'd0);
        end

        period = 16'd40;
        width  = 16'd4;

        // Capture and coding.
        do_conv(14'h2000, 14'h0000, 1'b0);
        do_conv(14'h3FFF, 14'h1FFF, 1'b0);
        do_conv(14'h0000, 14'h2000, 1'b0);
        do_conv(14'h0001, 14'h2001, 1'b0);
        do_conv(14'h1234, 14'h3234, 1'b0);

        // R9: EOC rise and data change without a fall produce nothing.
        @(negedge clk) begin eoc = 1'b1; adc_data = 14'h0AAA; end
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R9 no strobe", {31'd0, out_valid}, 32'd0);
        end
        chk("R9 raw held", {18'd0, out_raw}, 32'h1234);

        // R8: start rises while EOC is steadily high.
        @(negedge clk) enable = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk) enable = 1'b0;
        do_conv(14'h0100, 14'h2100, 1'b1);
        do_conv(14'h0200, 14'h2200, 1'b1);
        do_conv(14'h0300, 14'h2300, 1'b0);

        // R8: start rise in the same cycle as the capture of a sample.
        @(negedge clk) eoc = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk) begin eoc = 1'b0; adc_data = 14'h2ABC; end
        @(posedge clk);
        @(negedge clk) enable = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk) begin
            chk("R8 coincident strobe", {31'd0, out_valid}, 32'd1);
            chk("R8 coincident raw", {18'd0, out_raw}, 32'h2ABC);
            chk("R8 coincident clean", {31'd0, out_bad}, 32'd0);
            enable = 1'b0;
        end
        do_conv(14'h0011, 14'h2011, 1'b1);
        do_conv(14'h0022, 14'h2022, 1'b1);
        do_conv(14'h0033, 14'h2033, 1'b0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule